// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block brings a processor core back out of its low-power stop state. A STOP instruction signals `stop_entry`. The sequencer then drops the core clock enable and waits for the external wake request line to go low. That low level starts the clock generator and a settling delay. A mode input picks the length of the delay: a long count gives an on-chip oscillator time to settle, and a short count is for a clock that is already stable.

The wake request is ignored for most of the delay. Its synchronizer only advances again in the final few counts. At the end of the delay the sequencer records whether the wake request is still active. It then runs a fixed post-delay phase sequence. The first phase of that sequence carries a one-cycle arbitration strobe, where the recorded request competes with any other pending interrupt.

When the sequence ends, `done` pulses. `resume_next` accompanies it when nothing is left to service, which means the core continues with the instruction after STOP. Otherwise the highest-priority interrupt is taken.

Top module: `stop_wake_seq`

## Requirements
- R1: After synchronous reset (rst_n low), clk_enable is 1 and sync_enable, arbitrate, wake_irq_pending, resume_next and done are all 0.
- R2: While idle, stop_entry high at a clock edge makes clk_enable 0 from the next cycle on. It stays 0 until the settling delay has expired.
- R3: wake_req_n passes through two flops, and one more edge starts the delay. The delay then lasts LONG_COUNT cycles when short_delay is 0, or SHORT_COUNT cycles when short_delay is 1. short_delay is sampled only when the delay starts.
- R4: sync_enable is high during exactly the last SYNC_WINDOW cycles of the delay. Outside that window the wake synchronizer holds its value, so changes of wake_req_n there have no effect.
- R5: wake_irq_pending is set at expiry if the synchronized wake_req_n is 0 at that moment. This is the raw level two edges before expiry. A request released earlier, or a low pulse outside the window, leaves it 0.
- R6: arbitrate is a single-cycle pulse in the first cycle after the delay expires.
- R7: done is a single-cycle pulse POST_CYCLES cycles after arbitrate. resume_next is high with done exactly when neither wake_irq_pending nor int_pending_any was set in the arbitrate cycle. The sequencer is idle one cycle after done.
- R8: stop_entry has no effect while the sequencer is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stop_entry | input | 1 | Core has executed STOP |
| wake_req_n | input | 1 | External wake interrupt request, active low, asynchronous |
| short_delay | input | 1 | 1 selects the short settling count, 0 the long one |
| int_pending_any | input | 1 | Some other interrupt is pending at arbitration |
| clk_enable | output | 1 | Core clock enable |
| sync_enable | output | 1 | Interrupt input synchronization window is open |
| arbitrate | output | 1 | One-cycle strobe for interrupt arbitration |
| wake_irq_pending | output | 1 | Wake request recorded as pending |
| resume_next | output | 1 | With done: resume at the instruction after STOP |
| done | output | 1 | Wake-up sequence complete |

## Verification
The assertions assume that stop_entry comes only from a core that is running. They also assume that int_pending_any is a level that does not glitch around the arbitration cycle. The stimulus raises stop_entry only in idle, apart from a deliberate pulse in the post-delay phase that checks R8. It holds int_pending_any constant for the whole of each wake-up and changes wake_req_n only on falling clock edges. This keeps the synchronizer latency exact, so the release cycle can be swept across the expiry boundary.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

  typedef enum logic [2:0] {
    SEQ_RUN    = 3'd0,
    SEQ_HALT   = 3'd1,
    SEQ_SETTLE = 3'd2,
    SEQ_TAIL   = 3'd3,
    SEQ_DONE   = 3'd4
  } seq_state_e;

  // Reload value of the settling counter: length minus one.
  function automatic int unsigned settle_reload(input logic sel_short,
                                                input int unsigned long_n,
                                                input int unsigned short_n);
    return (sel_short ? short_n : long_n) - 1;
  endfunction

  // True in the final `win` counts of a down-count that ends at zero.
  function automatic logic in_final_window(input int unsigned remaining,
                                           input int unsigned win);
    return remaining < win;
  endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic din_n,
  output logic dout_n
);
  logic stage1_n;
  logic stage2_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_n <= 1'b1;
      stage2_n <= 1'b1;
    end else if (advance) begin
      stage1_n <= din_n;
      stage2_n <= stage1_n;
    end
  end

  assign dout_n = stage2_n;
endmodule

// File: rtl/settle_counter.sv
module settle_counter #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic [CW-1:0] count,
  output logic          at_zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (load)
      count <= load_val;
    else if (run && !at_zero)
      count <= count - 1'b1;
  end

  assign at_zero = (count == '0);
endmodule

// File: rtl/tail_counter.sv
module tail_counter #(
  parameter int PHASES = 17,
  localparam int TW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [TW-1:0] idx,
  output logic          first,
  output logic          last
);
  localparam logic [TW-1:0] LAST_IDX = TW'(PHASES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      idx <= '0;
    else if (idx != LAST_IDX)
      idx <= idx + 1'b1;
  end

  assign first = run && (idx == '0);
  assign last  = run && (idx == LAST_IDX);
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import stop_wake_pkg::*;
#(
  parameter int LONG_COUNT  = 131072,
  parameter int SHORT_COUNT = 16,
  parameter int SYNC_WINDOW = 4,
  parameter int POST_CYCLES = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_entry,
  input  logic wake_req_n,
  input  logic short_delay,
  input  logic int_pending_any,
  output logic clk_enable,
  output logic sync_enable,
  output logic arbitrate,
  output logic wake_irq_pending,
  output logic resume_next,
  output logic done
);
  localparam int CW = $clog2(LONG_COUNT);

  seq_state_e state, state_nx;

  // Named internal events
  logic          wake_sync_n;
  logic          seq_idle;
  logic          delay_start;
  logic          delay_expire;
  logic          in_settle;
  logic          in_tail;
  logic          tail_first;
  logic          tail_last;
  logic          sync_advance;
  logic [CW-1:0] settle_cnt;
  logic [CW-1:0] settle_load;
  logic          settle_zero;
  logic          service_flag;

  assign seq_idle  = (state == SEQ_RUN);
  assign in_settle = (state == SEQ_SETTLE);
  assign in_tail   = (state == SEQ_TAIL);

  assign sync_enable  = in_settle &&
                        in_final_window(int'(settle_cnt), SYNC_WINDOW);
  assign sync_advance = !in_settle || sync_enable;

  wake_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (sync_advance),
    .din_n   (wake_req_n),
    .dout_n  (wake_sync_n)
  );

  assign delay_start = (state == SEQ_HALT) && !wake_sync_n;
  assign settle_load = CW'(settle_reload(short_delay, LONG_COUNT, SHORT_COUNT));

  settle_counter #(.CW(CW)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (delay_start),
    .load_val (settle_load),
    .run      (in_settle),
    .count    (settle_cnt),
    .at_zero  (settle_zero)
  );

  assign delay_expire = in_settle && settle_zero;

  logic [((POST_CYCLES > 1) ? $clog2(POST_CYCLES) : 1)-1:0] tail_idx;

  tail_counter #(.PHASES(POST_CYCLES)) u_tail (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_tail),
    .idx   (tail_idx),
    .first (tail_first),
    .last  (tail_last)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      SEQ_RUN:    if (stop_entry)   state_nx = SEQ_HALT;
      SEQ_HALT:   if (delay_start)  state_nx = SEQ_SETTLE;
      SEQ_SETTLE: if (delay_expire) state_nx = SEQ_TAIL;
      SEQ_TAIL:   if (tail_last)    state_nx = SEQ_DONE;
      SEQ_DONE:                     state_nx = SEQ_RUN;
      default:                      state_nx = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      state <= SEQ_RUN;
    else
      state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || delay_start || state == SEQ_DONE)
      wake_irq_pending <= 1'b0;
    else if (delay_expire)
      wake_irq_pending <= !wake_sync_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || delay_start)
      service_flag <= 1'b0;
    else if (tail_first)
      service_flag <= wake_irq_pending || int_pending_any;
  end

  assign arbitrate   = tail_first;
  assign done        = (state == SEQ_DONE);
  assign resume_next = done && !service_flag;
  assign clk_enable  = !((state == SEQ_HALT) || in_settle);

endmodule

// File: rtl/stop_wake_chk.sv
module stop_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_entry,
  input logic clk_enable,
  input logic sync_enable,
  input logic arbitrate,
  input logic wake_irq_pending,
  input logic resume_next,
  input logic done,
  input logic seq_idle,
  input logic delay_expire,
  input logic wake_sync_n
);
  // R2
  halt_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && stop_entry) |=> !clk_enable);

  // R4
  window_clock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_enable |-> !clk_enable);

  // R5
  pending_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delay_expire |=> (wake_irq_pending == !$past(wake_sync_n)));

  // R6
  arb_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arbitrate |-> $past(delay_expire));

  // R6
  arb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arbitrate |=> !arbitrate);

  // R7
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && seq_idle && clk_enable));

  // R7
  resume_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_next |-> done);
endmodule

bind stop_wake_seq stop_wake_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .stop_entry       (stop_entry),
  .clk_enable       (clk_enable),
  .sync_enable      (sync_enable),
  .arbitrate        (arbitrate),
  .wake_irq_pending (wake_irq_pending),
  .resume_next      (resume_next),
  .done             (done),
  .seq_idle         (seq_idle),
  .delay_expire     (delay_expire),
  .wake_sync_n      (wake_sync_n)
);

// File: tb/stop_wake_seq_bench.sv
module stop_wake_seq_bench;
  localparam int LONG_N  = 24;
  localparam int SHORT_N = 8;
  localparam int WIN     = 4;
  localparam int POST    = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_entry = 1'b0;
  logic wake_req_n = 1'b1;
  logic short_delay = 1'b0;
  logic int_pending_any = 1'b0;
  logic clk_enable, sync_enable, arbitrate, wake_irq_pending, resume_next, done;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  stop_wake_seq #(
    .LONG_COUNT (LONG_N),
    .SHORT_COUNT(SHORT_N),
    .SYNC_WINDOW(WIN),
    .POST_CYCLES(POST)
  ) u_stop_wake_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .stop_entry       (stop_entry),
    .wake_req_n       (wake_req_n),
    .short_delay      (short_delay),
    .int_pending_any  (int_pending_any),
    .clk_enable       (clk_enable),
    .sync_enable      (sync_enable),
    .arbitrate        (arbitrate),
    .wake_irq_pending (wake_irq_pending),
    .resume_next      (resume_next),
    .done             (done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One stop / wake cycle. Wake goes low at step 0 and is released at step rel.
  task automatic wake_run(input logic mode, input int rel, input logic other, input logic pulse);
    int n = mode ? SHORT_N : LONG_N;
    int arb_at = -1, done_at = -1, arb_cnt = 0, done_cnt = 0;
    int sync_cnt = 0, sync_first = -1, off_cnt = 0;
    int pend_at_done = -1, res_at_done = -1;
    int exp_pend = (rel > n) ? 1 : 0;
    int exp_res  = (exp_pend == 0 && !other) ? 1 : 0;
    @(negedge clk);
    int_pending_any = other;
    stop_entry = 1'b1;
    @(negedge clk);
    stop_entry = 1'b0;
    check("R2 clock off after entry", clk_enable, 0);
    @(negedge clk);
    check("R2 clock stays off", clk_enable, 0);
    short_delay = mode;
    wake_req_n  = 1'b0;
    for (int j = 1; j <= n + 24; j++) begin
      @(negedge clk);
      if (arbitrate) begin arb_cnt++; if (arb_at < 0) arb_at = j; end
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = j;
        pend_at_done = wake_irq_pending;
        res_at_done  = resume_next;
      end
      if (sync_enable) begin sync_cnt++; if (sync_first < 0) sync_first = j; end
      if (!clk_enable) off_cnt++;
      if (j == 4) short_delay = !mode;
      if (j == rel) wake_req_n = 1'b1;
      if (pulse && j == rel + 3) wake_req_n = 1'b0;
      if (pulse && j == rel + 5) wake_req_n = 1'b1;
      if (j == n + 6) stop_entry = 1'b1;
      if (j == n + 7) stop_entry = 1'b0;
    end
    wake_req_n = 1'b1;
    // R3: delay length follows the mode sampled at start
    check("R3 clock-off span", off_cnt, n + 2);
    check("R4 window length", sync_cnt, WIN);
    check("R4 window start", sync_first, n + 3 - WIN);
    check("R5 pending at done", pend_at_done, exp_pend);
    check("R6 arbitrate step", arb_at, n + 3);
    check("R6 arbitrate count", arb_cnt, 1);
    check("R7 done step", done_at, n + 3 + POST);
    check("R7 done count", done_cnt, 1);
    check("R7 resume_next", res_at_done, exp_res);
    // R8: stop entry during the tail left the core running
    check("R8 stop ignored", clk_enable, 1);
    @(negedge clk);
    check("R8 still running", clk_enable, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 clk_enable", clk_enable, 1);
    check("R1 sync_enable", sync_enable, 0);
    check("R1 arbitrate", arbitrate, 0);
    check("R1 pending", wake_irq_pending, 0);
    check("R1 resume_next", resume_next, 0);
    check("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int r = 1; r <= (m ? SHORT_N : LONG_N) + 3; r++)
        wake_run(logic'(m), r, logic'(r % 2), r == 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule